// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block watches a stream of memory references and measures, for each one, its stack distance. The stack distance is how many distinct cache blocks were touched since the previous reference to the same block. Each byte address is first turned into a block number by dropping the offset bits inside a line. The block number is then looked up in a recency-ordered stack of the most recently used distinct blocks. A block found at depth k has distance k. A block that is absent is reported as infinite. The referenced block then moves to the top of the stack.

A fully-associative LRU cache of n lines hits exactly those references whose distance is n-1 or less. One pass over a trace therefore shows the hit behaviour of every cache size up to the stack depth at once. Each distance is also counted in a histogram. The histogram has one saturating counter for each finite depth and one counter for infinite results. Any counter can be read by index, and all counters can be cleared together.

Top module: `lru_dist_mon`

## Requirements
- R1: The block number is `ref_addr >> log2(LINE_BYTES)`. Two addresses inside the same line are the same block.
- R2: A reference to a block that is not in the stack gives `res_inf`=1 and `res_dist`=0.
- R3: A reference to a block that is in the stack gives `res_inf`=0. Its `res_dist` equals the number of distinct blocks referenced since the last reference to that block. A block repeated immediately gives 0.
- R4: `res_valid` is high in the cycle after each cycle with `ref_valid` high, and low otherwise.
- R5: References on consecutive cycles are each looked up in the stack as updated by all earlier references.
- R6: The stack holds DEPTH distinct blocks. A new block enters at the top and drops the bottom entry. A block pushed below depth DEPTH-1 is then reported as infinite.
- R7: Histogram bin k (0 ≤ k < DEPTH) counts results with distance k. Bin DEPTH counts infinite results. Each count becomes visible on `hist_count` in the same cycle that `res_valid` shows the result.
- R8: Histogram counters saturate at 2^CNT_W-1 and do not wrap.
- R9: When `hist_clear` is high at a clock edge, all bins become 0. This takes priority over an increment at the same edge. The stack and the result output are not affected.
- R10: `hist_count` shows bin `hist_sel` combinationally. An index above DEPTH reads 0.
- R11: After reset, `res_valid` is 0, all bins are 0 and the stack is empty, so the next reference is infinite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | ADDR_W | Byte address of the reference |
| res_valid | output | 1 | Result of the previous cycle's reference |
| res_dist | output | $clog2(DEPTH) | Stack distance (0 when infinite) |
| res_inf | output | 1 | Block was not in the stack |
| hist_clear | input | 1 | Synchronous clear of all histogram bins |
| hist_sel | input | $clog2(DEPTH+1) | Histogram bin index to read |
| hist_count | output | CNT_W | Count of the selected bin |

## Verification
The bench builds the block with 8-byte lines, a 16-bit address, a stack depth of 4 and 4-bit counters. With a depth of 4, the eight-reference example stream (infinite, infinite, 1, 0, 1, infinite, infinite, 3) reaches the bottom entry. A fifth distinct block then pushes an older block out of the stack, so its return is reported as infinite. The 4-bit counters reach saturation after fifteen repeats, and the 3-bit index can address the unused codes 5 to 7.

// File: rtl/lru_dist_pkg.sv
`timescale 1ns/1ps
package lru_dist_pkg;
  // Smallest stack the lookup logic supports (a distance needs at least one bit).
  localparam int unsigned MIN_DEPTH = 2;

  // Number of histogram bins: one per finite depth plus one for "not found".
  function automatic int unsigned bin_total(input int unsigned depth);
    return depth + 1;
  endfunction
endpackage

// File: rtl/dist_stack.sv
`timescale 1ns/1ps
module dist_stack #(
  parameter int unsigned BLK_W = 26,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DIST_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [BLK_W-1:0]  blk,
  output logic              hit,
  output logic [DIST_W-1:0] pos
);
  logic [BLK_W-1:0]  ent_q [DEPTH];
  logic [BLK_W-1:0]  ent_d [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;
  logic [DEPTH-1:0]  match;
  logic [DIST_W-1:0] lim;

  // Lookup: entries are distinct, so at most one matches.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = vld_q[i] && (ent_q[i] == blk);
    end
    hit = |match;
    pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) pos = DIST_W'(i);
    end
  end

  // Move-to-front: entries above the match (or all, on a miss) slide down.
  always_comb begin
    lim = hit ? pos : DIST_W'(DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) begin
        ent_d[i] = blk;
        vld_d[i] = 1'b1;
      end else if (DIST_W'(i) <= lim) begin
        ent_d[i] = ent_q[i-1];
        vld_d[i] = vld_q[i-1];
      end else begin
        ent_d[i] = ent_q[i];
        vld_d[i] = vld_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (upd) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end
endmodule

// File: rtl/dist_hist.sv
`timescale 1ns/1ps
module dist_hist #(
  parameter int unsigned NBIN  = 9,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SEL_W = $clog2(NBIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [SEL_W-1:0] inc_bin,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] rd
);
  logic [CNT_W-1:0] cnt_all [NBIN];

  for (genvar g = 0; g < NBIN; g++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             bump;

    always_comb begin
      bump  = inc && (inc_bin == SEL_W'(g)) && (cnt_q != {CNT_W{1'b1}});
      cnt_d = cnt_q;
      if (clr) begin
        cnt_d = '0;
      end else if (bump) begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (clr || bump) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_all[g] = cnt_q;
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < NBIN; i++) begin
      if (sel == SEL_W'(i)) rd = cnt_all[i];
    end
  end
endmodule

// File: rtl/lru_dist_mon.sv
`timescale 1ns/1ps
module lru_dist_mon
  import lru_dist_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned DIST_W    = $clog2(DEPTH),
  localparam int unsigned SEL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              res_valid,
  output logic [DIST_W-1:0] res_dist,
  output logic              res_inf,
  input  logic              hist_clear,
  input  logic [SEL_W-1:0]  hist_sel,
  output logic [CNT_W-1:0]  hist_count
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned BLK_W = ADDR_W - OFF_W;
  localparam int unsigned NBIN  = bin_total(DEPTH);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [BLK_W-1:0]  blk;
  logic              hit;
  logic [DIST_W-1:0] pos;
  logic [SEL_W-1:0]  bin;
  logic              vld_d;
  logic [DIST_W-1:0] dist_d;
  logic              inf_d;

  assign blk = ref_addr[ADDR_W-1:OFF_W];

  dist_stack #(.BLK_W(BLK_W), .DEPTH(DEPTH)) stack_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .upd  (ref_valid),
    .blk  (blk),
    .hit  (hit),
    .pos  (pos)
  );

  assign bin = hit ? SEL_W'(pos) : SEL_W'(DEPTH);

  dist_hist #(.NBIN(NBIN), .CNT_W(CNT_W)) hist_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (hist_clear),
    .inc    (ref_valid),
    .inc_bin(bin),
    .sel    (hist_sel),
    .rd     (hist_count)
  );

  // Result register: one cycle after the reference.
  always_comb begin
    vld_d  = ref_valid;
    inf_d  = !hit;
    dist_d = hit ? pos : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_d) begin
      res_dist <= dist_d;
      res_inf  <= inf_d;
    end
  end
endmodule

// File: rtl/lru_dist_mon_chk.sv
`timescale 1ns/1ps
module lru_dist_mon_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned DIST_W    = $clog2(DEPTH),
  localparam int unsigned SEL_W     = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_valid,
  input logic [ADDR_W-1:0] ref_addr,
  input logic              res_valid,
  input logic [DIST_W-1:0] res_dist,
  input logic              res_inf,
  input logic              hist_clear,
  input logic [SEL_W-1:0]  hist_sel,
  input logic [CNT_W-1:0]  hist_count
);
  logic                    last_vld_q;
  logic [ADDR_W-OFF_W-1:0] last_blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q <= 1'b0;
      last_blk_q <= '0;
    end else if (ref_valid) begin
      last_vld_q <= 1'b1;
      last_blk_q <= ref_addr[ADDR_W-1:OFF_W];
    end
  end

  AST_RES_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> res_valid); // R4
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !res_valid); // R4
  AST_INF_DIST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_inf) |-> (res_dist == '0)); // R2
  AST_REPEAT_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && last_vld_q && (ref_addr[ADDR_W-1:OFF_W] == last_blk_q))
    |=> (res_valid && !res_inf && (res_dist == '0))); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clear |=> (hist_count == '0)); // R9
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_sel > SEL_W'(DEPTH)) |-> (hist_count == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hist_count) == {CNT_W{1'b1}}) && $stable(hist_sel) && !$past(hist_clear))
    |-> (hist_count == {CNT_W{1'b1}})); // R8
endmodule

bind lru_dist_mon lru_dist_mon_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
  .res_valid(res_valid), .res_dist(res_dist), .res_inf(res_inf),
  .hist_clear(hist_clear), .hist_sel(hist_sel), .hist_count(hist_count)
);

// File: tb/lru_dist_mon_tb_top.sv
`timescale 1ns/1ps
module lru_dist_mon_tb_top;
  localparam int unsigned AW    = 16;
  localparam int unsigned LB    = 8;
  localparam int unsigned DEP   = 4;
  localparam int unsigned CW    = 4;
  localparam int unsigned DW    = $clog2(DEP);
  localparam int unsigned SW    = $clog2(DEP + 1);
  localparam int unsigned VW    = AW + 1 + DW;
  localparam int          NV    = 13;

  logic          clk;
  logic          rst_n;
  logic          ref_valid;
  logic [AW-1:0] ref_addr;
  logic          res_valid;
  logic [DW-1:0] res_dist;
  logic          res_inf;
  logic          hist_clear;
  logic [SW-1:0] hist_sel;
  logic [CW-1:0] hist_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  lru_dist_mon #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DEP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
    .res_valid(res_valid), .res_dist(res_dist), .res_inf(res_inf),
    .hist_clear(hist_clear), .hist_sel(hist_sel), .hist_count(hist_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vectors: {byte address, expected infinite, expected distance}.
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'd0,  1'b1, 2'd0},   // block 0 first
    {16'd8,  1'b1, 2'd0},   // block 1 first
    {16'd4,  1'b0, 2'd1},   // block 0 again (same line as 0)
    {16'd4,  1'b0, 2'd0},   // immediate repeat
    {16'd12, 1'b0, 2'd1},   // block 1
    {16'd16, 1'b1, 2'd0},   // block 2 first
    {16'd32, 1'b1, 2'd0},   // block 4 first
    {16'd4,  1'b0, 2'd3},   // block 0 at bottom
    {16'd40, 1'b1, 2'd0},   // block 5 pushes block 1 out
    {16'd9,  1'b1, 2'd0},   // block 1 was dropped
    {16'd33, 1'b0, 2'd3},   // block 4
    {16'd7,  1'b0, 2'd3},   // block 0
    {16'd0,  1'b0, 2'd0}    // block 0 repeat
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one reference; check the result one edge later.
  task automatic do_ref(input logic [AW-1:0] a, input bit e_inf, input int e_dist,
                        input string req);
    ref_valid = 1'b1;
    ref_addr  = a;
    @(posedge clk);
    #1;
    ref_valid = 1'b0;
    check({req, " res_valid"}, int'(res_valid), 1);
    check({req, " res_inf"},   int'(res_inf),   int'(e_inf));
    check({req, " res_dist"},  int'(res_dist),  e_dist);
  endtask

  task automatic chk_bin(input int idx, input int exp, input string req);
    hist_sel = SW'(idx);
    #0.5;
    check({req, $sformatf(" bin%0d", idx)}, int'(hist_count), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    ref_valid  = 1'b0;
    ref_addr   = '0;
    hist_clear = 1'b0;
    hist_sel   = '0;
    do_reset();

    // R11: reset state
    check("R11 res_valid after reset", int'(res_valid), 0);
    for (int b = 0; b <= DEP; b++) chk_bin(b, 0, "R11");

    // R1 R2 R3 R5 R6: back-to-back vector walk
    for (int k = 0; k < NV; k++) begin
      do_ref(VEC[k][VW-1:DW+1], VEC[k][DW], int'(VEC[k][DW-1:0]),
             $sformatf("R3/R5/R6 vec%0d", k));
    end
    // R4: idle cycle gives no result
    @(posedge clk); #1;
    check("R4 idle res_valid", int'(res_valid), 0);

    // R7: histogram of the 13 references
    chk_bin(0, 2, "R7");
    chk_bin(1, 2, "R7");
    chk_bin(2, 0, "R7");
    chk_bin(3, 3, "R7");
    chk_bin(4, 6, "R7");
    // R10: out-of-range index
    chk_bin(5, 0, "R10");
    chk_bin(7, 0, "R10");

    // R9: clear together with a reference; clear wins, stack kept
    hist_clear = 1'b1;
    do_ref(16'd2, 1'b0, 0, "R9 ref during clear");
    hist_clear = 1'b0;
    for (int b = 0; b <= DEP; b++) chk_bin(b, 0, "R9");

    // R8: saturation with 20 repeats of block 0
    for (int k = 0; k < 20; k++) do_ref(16'd1, 1'b0, 0, "R8 repeat");
    chk_bin(0, 15, "R8 saturated");
    chk_bin(4, 0, "R8 inf bin");

    // R11: reset in the middle empties the stack and histogram
    do_reset();
    check("R11 res_valid mid reset", int'(res_valid), 0);
    chk_bin(0, 0, "R11 mid reset");
    do_ref(16'd0, 1'b1, 0, "R11 stack empty");
    // R1: address 7 shares block 0
    do_ref(16'd7, 1'b0, 0, "R1 same line");
    do_ref(16'd8, 1'b1, 0, "R1 next line");
    chk_bin(4, 2, "R7 after reset");
    chk_bin(0, 1, "R7 after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule